// File: doc/BRIEF.md
# Multiphase Phase-Count Strap Detector

This block runs once at startup of a multiphase buck controller to work out how many power phases are fitted. The board marks unused phases by tying their current-sense inputs to the supply; an external comparator turns each of the phase 2, 3 and 4 pins into a one-bit strap flag. Only three flag combinations are legal, plus the all-low default.

Detection starts when enable is high and a start strobe arrives while the block is idle. A timed window then opens. During the window the test current sinks on the three sense pins are switched on and PWM1 is held low. On the last cycle of the window the flags are sampled and decoded. The results are then latched, and a one-cycle done strobe is raised. The results are:
- the active phase count;
- a high-impedance mask for unused PWM outputs;
- the ramp phase spacing in degrees;
- a configuration-error flag;
- the phase count used in the light-load power state. A boot-configuration input selects one or two phases for this state, limited by the detected count.

The results stay fixed until enable falls. Dropping enable also cancels a window that is in progress.

Top module: `phase_count_detect`

## Requirements
- R1: After reset, and while idle, every output is zero: no sinks, no PWM1 hold, no done, count 0, mask 0000, spacing 0, no error, light-load count 0.
- R2: A window starts only on a start strobe sampled while enable is high and the block is idle. A strobe sampled with enable low has no effect.
- R3: For exactly DETECT_CYCLES clock cycles, beginning the cycle after the accepted strobe, all three test sinks are enabled and PWM1 hold-low is asserted.
- R4: In the cycle after the window ends, the sinks and hold are off, and done is high for exactly one cycle. In that same cycle the results become valid.
- R5: Strap vector {p4,p3,p2} = 000 gives count 4, mask 0000, spacing 90.
- R6: Strap 100 (phase 4 only) gives count 3, mask 1000, spacing 120.
- R7: Strap 101 (phases 2 and 4) gives count 2, mask 1010, spacing 180.
- R8: Strap 111 gives count 1, mask 1110, spacing 0, with no error.
- R9: Straps 001, 010, 011 and 110 raise the configuration-error flag and fall back to count 1, mask 1110, spacing 0.
- R10: The light-load count is 2 when the boot select input is 1 and the detected count is at least 2; otherwise it is 1.
- R11: Once results are latched, strap changes and further start strobes leave every result unchanged while enable stays high.
- R12: Enable low clears all results and aborts an open window; the sinks are off in the next cycle.

Bit and field conventions used by the requirements:
- Strap bit 0 is phase 2, bit 1 is phase 3 and bit 2 is phase 4.
- Mask bit i is PWM phase i+1; a 1 means that output is high impedance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Controller enable; low clears and aborts |
| start_det | input | 1 | Start-detection strobe |
| strap_hi | input | 3 | Strap flags for phases 2, 3, 4 (bits 0, 1, 2) |
| boot_ps1_two | input | 1 | Boot code: 1 selects two phases in light load |
| sink_en | output | 3 | Test current sink enables for phases 2, 3, 4 |
| pwm1_hold_low | output | 1 | Hold PWM1 low during detection |
| det_done | output | 1 | One-cycle strobe when results become valid |
| phase_count | output | 3 | Detected active phase count (0 when not valid) |
| pwm_tristate | output | 4 | High-impedance mask, bit i = phase i+1 |
| ramp_spacing | output | 9 | Ramp phase offset between active phases, degrees |
| cfg_err | output | 1 | Illegal strap combination seen |
| ps1_count | output | 3 | Phase count for the light-load power state |

## Verification
The assertions rely on two assumptions about the inputs:
- Enable goes low only through the block's normal clear path, so a window always ends either by timing out or by enable dropping. Under that assumption, the sink-cycle counter in the checker measures exactly one window.
- Strap flags are stable through the final window cycle.

The bench meets both assumptions. It changes straps and the boot select only while idle, or deliberately after results are latched to show they are ignored. It drives every input on the falling edge, so no flag moves at a sampling edge.

// File: rtl/ph_det_pkg.sv
// Package: shared types for the phase-count strap detector.
// Assumes a four-phase maximum; strap bit 0/1/2 map to phases 2/3/4.
package ph_det_pkg;

    localparam int MAX_PHASES = 4;
    localparam int STRAP_W    = MAX_PHASES - 1;
    localparam int CNT_W      = $clog2(MAX_PHASES + 1);
    localparam int DEG_W      = 9;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WINDOW = 2'd1,
        ST_LOCKED = 2'd2
    } det_state_t;

    typedef struct packed {
        logic [CNT_W-1:0]      count;
        logic [MAX_PHASES-1:0] tristate;
        logic [DEG_W-1:0]      spacing;
        logic                  err;
        logic [CNT_W-1:0]      ps1_count;
    } det_result_t;

endpackage

// File: rtl/det_window_ctrl.sv
// Window controller: sequences idle -> timed detection window -> locked.
// Assumes start_det is a strobe; enable low returns to idle from any state.
module det_window_ctrl
    import ph_det_pkg::*;
#(
    parameter int DETECT_CYCLES = 30
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic start_det,
    output logic in_window,
    output logic window_end
);
    localparam int TW = (DETECT_CYCLES > 1) ? $clog2(DETECT_CYCLES) : 1;
    localparam logic [TW-1:0] LAST = TW'(DETECT_CYCLES - 1);

    det_state_t    state;
    logic [TW-1:0] tick;

    // State and window timer update.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            state <= ST_IDLE;
            tick  <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    tick <= '0;
                    if (start_det) state <= ST_WINDOW;
                end
                ST_WINDOW: begin
                    if (tick == LAST) begin
                        state <= ST_LOCKED;
                        tick  <= '0;
                    end else begin
                        tick <= tick + 1'b1;
                    end
                end
                default: tick <= '0;
            endcase
        end
    end

    // Window flags derived from state and timer.
    always_comb begin
        in_window  = (state == ST_WINDOW);
        window_end = (state == ST_WINDOW) && (tick == LAST);
    end
endmodule

// File: rtl/strap_decode.sv
// Strap decoder: maps {p4,p3,p2} flags to count, mask, spacing, error, PS1 count.
// Assumes illegal combinations fall back to single-phase operation.
module strap_decode
    import ph_det_pkg::*;
(
    input  logic [STRAP_W-1:0] strap_hi,
    input  logic               boot_ps1_two,
    output det_result_t        res
);
    // Combinational decode of the strap pattern.
    always_comb begin
        res = '0;
        unique case (strap_hi)
            3'b000: begin res.count = 3'd4; res.tristate = 4'b0000; end
            3'b100: begin res.count = 3'd3; res.tristate = 4'b1000; end
            3'b101: begin res.count = 3'd2; res.tristate = 4'b1010; end
            3'b111: begin res.count = 3'd1; res.tristate = 4'b1110; end
            default: begin
                res.count    = 3'd1;
                res.tristate = 4'b1110;
                res.err      = 1'b1;
            end
        endcase
        res.spacing   = (res.count > 3'd1) ? DEG_W'(360 / int'(res.count)) : '0;
        res.ps1_count = (boot_ps1_two && res.count >= 3'd2) ? 3'd2 : 3'd1;
    end
endmodule

// File: rtl/result_hold.sv
// Result register: captures decoded results at window end, holds until enable drops.
// Assumes capture is a single-cycle pulse.
module result_hold
    import ph_det_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        enable,
    input  logic        capture,
    input  det_result_t d,
    output det_result_t q,
    output logic        done
);
    // Capture, hold, or clear the latched results.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            q    <= '0;
            done <= 1'b0;
        end else if (capture) begin
            q    <= d;
            done <= 1'b1;
        end else begin
            done <= 1'b0;
        end
    end
endmodule

// File: rtl/phase_count_detect.sv
// Top: startup phase-count detector. Runs a timed strap-detection window,
// drives the test sinks and PWM1 hold, then publishes latched phase results.
// Assumes strap flags come from an external comparator, already synchronous.
module phase_count_detect
    import ph_det_pkg::*;
#(
    parameter int DETECT_CYCLES = 30
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  enable,
    input  logic                  start_det,
    input  logic [STRAP_W-1:0]    strap_hi,
    input  logic                  boot_ps1_two,
    output logic [STRAP_W-1:0]    sink_en,
    output logic                  pwm1_hold_low,
    output logic                  det_done,
    output logic [CNT_W-1:0]      phase_count,
    output logic [MAX_PHASES-1:0] pwm_tristate,
    output logic [DEG_W-1:0]      ramp_spacing,
    output logic                  cfg_err,
    output logic [CNT_W-1:0]      ps1_count
);
    logic        in_window;
    logic        window_end;
    det_result_t decoded;
    det_result_t held;

    det_window_ctrl #(.DETECT_CYCLES(DETECT_CYCLES)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .start_det  (start_det),
        .in_window  (in_window),
        .window_end (window_end)
    );

    strap_decode u_dec (
        .strap_hi     (strap_hi),
        .boot_ps1_two (boot_ps1_two),
        .res          (decoded)
    );

    result_hold u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (enable),
        .capture (window_end),
        .d       (decoded),
        .q       (held),
        .done    (det_done)
    );

    // One sink enable per detectable phase, all active during the window.
    for (genvar g = 0; g < STRAP_W; g++) begin : g_sink
        assign sink_en[g] = in_window;
    end

    assign pwm1_hold_low = in_window;
    assign phase_count   = held.count;
    assign pwm_tristate  = held.tristate;
    assign ramp_spacing  = held.spacing;
    assign cfg_err       = held.err;
    assign ps1_count     = held.ps1_count;
endmodule

// File: rtl/phase_count_detect_chk.sv
// Checker: temporal properties of the phase-count detector, bound to the top.
// Assumes straps are stable over the last window cycle.
module phase_count_detect_chk
    import ph_det_pkg::*;
#(
    parameter int DETECT_CYCLES = 30
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  enable,
    input logic                  start_det,
    input logic [STRAP_W-1:0]    strap_hi,
    input logic                  boot_ps1_two,
    input logic [STRAP_W-1:0]    sink_en,
    input logic                  pwm1_hold_low,
    input logic                  det_done,
    input logic [CNT_W-1:0]      phase_count,
    input logic [MAX_PHASES-1:0] pwm_tristate,
    input logic [DEG_W-1:0]      ramp_spacing,
    input logic                  cfg_err,
    input logic [CNT_W-1:0]      ps1_count
);
    localparam int WW = $clog2(DETECT_CYCLES + 2);
    logic [WW-1:0] win_cnt;

    // Count consecutive cycles with the sinks enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)          win_cnt <= '0;
        else if (sink_en[0]) win_cnt <= win_cnt + 1'b1;
        else                 win_cnt <= '0;
    end

    assert_hold_with_sinks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sink_en != '0) |-> (pwm1_hold_low && sink_en == '1));

    assert_window_length_R3: assert property (@(posedge clk) disable iff (!rst_n)
        det_done |-> (win_cnt == WW'(DETECT_CYCLES) && sink_en == '0));

    assert_done_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        det_done |=> !det_done);

    assert_done_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
        det_done |-> (phase_count != '0 && ps1_count != '0));

    assert_mask_matches_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_count != '0) |-> ($countones(~pwm_tristate) == int'(phase_count)));

    assert_latched_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && phase_count != '0) |=>
            ($stable(phase_count) && $stable(pwm_tristate) && $stable(ramp_spacing)
             && $stable(cfg_err) && $stable(ps1_count)));

    assert_enable_clears_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (phase_count == '0 && sink_en == '0 && !det_done));
endmodule

bind phase_count_detect phase_count_detect_chk #(.DETECT_CYCLES(DETECT_CYCLES)) u_chk (.*);

// File: tb/tb_phase_count_detect.sv
// Bench: vector table walked for all strap/boot combinations, then directed tests.
module tb_phase_count_detect;
    localparam int DC = 30;

    logic       clk = 1'b0;
    logic       rst_n, enable, start_det, boot_ps1_two;
    logic [2:0] strap_hi;
    logic [2:0] sink_en;
    logic       pwm1_hold_low, det_done, cfg_err;
    logic [2:0] phase_count, ps1_count;
    logic [3:0] pwm_tristate;
    logic [8:0] ramp_spacing;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    phase_count_detect #(.DETECT_CYCLES(DC)) dut (.*);

    // {strap, boot, count, mask, spacing, err, ps1}
    localparam logic [23:0] VEC [16] = '{
        {3'b000, 1'b0, 3'd4, 4'b0000, 9'd90,  1'b0, 3'd1},
        {3'b000, 1'b1, 3'd4, 4'b0000, 9'd90,  1'b0, 3'd2},
        {3'b001, 1'b0, 3'd1, 4'b1110, 9'd0,   1'b1, 3'd1},
        {3'b001, 1'b1, 3'd1, 4'b1110, 9'd0,   1'b1, 3'd1},
        {3'b010, 1'b0, 3'd1, 4'b1110, 9'd0,   1'b1, 3'd1},
        {3'b010, 1'b1, 3'd1, 4'b1110, 9'd0,   1'b1, 3'd1},
        {3'b011, 1'b0, 3'd1, 4'b1110, 9'd0,   1'b1, 3'd1},
        {3'b011, 1'b1, 3'd1, 4'b1110, 9'd0,   1'b1, 3'd1},
        {3'b100, 1'b0, 3'd3, 4'b1000, 9'd120, 1'b0, 3'd1},
        {3'b100, 1'b1, 3'd3, 4'b1000, 9'd120, 1'b0, 3'd2},
        {3'b101, 1'b0, 3'd2, 4'b1010, 9'd180, 1'b0, 3'd1},
        {3'b101, 1'b1, 3'd2, 4'b1010, 9'd180, 1'b0, 3'd2},
        {3'b110, 1'b0, 3'd1, 4'b1110, 9'd0,   1'b1, 3'd1},
        {3'b110, 1'b1, 3'd1, 4'b1110, 9'd0,   1'b1, 3'd1},
        {3'b111, 1'b0, 3'd1, 4'b1110, 9'd0,   1'b0, 3'd1},
        {3'b111, 1'b1, 3'd1, 4'b1110, 9'd0,   1'b0, 3'd1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_results(input string req, input logic [23:0] v);
        chk({req, " count"},   32'(phase_count),  32'(v[19:17]));
        chk({req, " mask"},    32'(pwm_tristate), 32'(v[16:13]));
        chk({req, " spacing"}, 32'(ramp_spacing), 32'(v[12:4]));
        chk({req, " err"},     32'(cfg_err),      32'(v[3]));
        chk({req, " ps1"},     32'(ps1_count),    32'(v[2:0]));
    endtask

    // Clear with enable low, then run one full window; leaves results latched.
    task automatic run_window(input logic [2:0] s, input logic b);
        @(negedge clk); enable = 1'b0; start_det = 1'b0;
        @(negedge clk); enable = 1'b1; strap_hi = s; boot_ps1_two = b; start_det = 1'b1;
        @(negedge clk); start_det = 1'b0;
        chk("R3 sinks at window start", 32'(sink_en), 32'd7);
        chk("R3 pwm1 hold at start", 32'(pwm1_hold_low), 32'd1);
        repeat (DC - 1) @(negedge clk);
        chk("R3 sinks at last window cycle", 32'(sink_en), 32'd7);
        chk("R3 no early done", 32'(det_done), 32'd0);
        @(negedge clk);
        chk("R4 sinks off after window", 32'(sink_en), 32'd0);
        chk("R4 hold off after window", 32'(pwm1_hold_low), 32'd0);
        chk("R4 done strobe", 32'(det_done), 32'd1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog R1..all actual expired expected finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; enable = 1'b0; start_det = 1'b0; strap_hi = 3'b000; boot_ps1_two = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 sinks", 32'(sink_en), 32'd0);
        chk("R1 done", 32'(det_done), 32'd0);
        chk("R1 count", 32'(phase_count), 32'd0);
        chk("R1 mask", 32'(pwm_tristate), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle hold", 32'(pwm1_hold_low), 32'd0);

        // R2: strobe with enable low is ignored
        start_det = 1'b1;
        @(negedge clk); start_det = 1'b0;
        chk("R2 no window when disabled", 32'(sink_en), 32'd0);
        @(negedge clk);
        chk("R2 no window when disabled (late)", 32'(sink_en), 32'd0);

        // R5..R10: all strap and boot combinations
        for (int i = 0; i < 16; i++) begin
            run_window(VEC[i][23:21], VEC[i][20]);
            chk_results("R5-R10 table", VEC[i]);
            @(negedge clk);
            chk("R4 done single cycle", 32'(det_done), 32'd0);
        end

        // R6 named check, plus R11: straps change and restart ignored after lock
        run_window(3'b100, 1'b1);
        chk_results("R6", VEC[9]);
        @(negedge clk); strap_hi = 3'b111; boot_ps1_two = 1'b0; start_det = 1'b1;
        @(negedge clk); start_det = 1'b0;
        chk("R11 no new window", 32'(sink_en), 32'd0);
        repeat (DC + 2) @(negedge clk);
        chk_results("R11 latched", VEC[9]);
        chk("R11 no second done", 32'(det_done), 32'd0);

        // R12: enable low clears latched results
        enable = 1'b0;
        @(negedge clk);
        chk("R12 clear count", 32'(phase_count), 32'd0);
        chk("R12 clear mask", 32'(pwm_tristate), 32'd0);
        chk("R12 clear spacing", 32'(ramp_spacing), 32'd0);

        // R12: abort mid window
        enable = 1'b1; strap_hi = 3'b101; start_det = 1'b1;
        @(negedge clk); start_det = 1'b0;
        repeat (5) @(negedge clk);
        chk("R12 window open before abort", 32'(sink_en), 32'd7);
        enable = 1'b0;
        @(negedge clk);
        chk("R12 sinks off on abort", 32'(sink_en), 32'd0);
        enable = 1'b1;
        repeat (DC + 2) @(negedge clk);
        chk("R12 no done after abort", 32'(phase_count), 32'd0);

        // R7, R8, R9 named directed checks
        run_window(3'b101, 1'b0);
        chk_results("R7", VEC[10]);
        run_window(3'b111, 1'b1);
        chk_results("R8", VEC[15]);
        run_window(3'b010, 1'b1);
        chk_results("R9", VEC[5]);
        // R10: boot select limited by single phase
        chk("R10 ps1 limited", 32'(ps1_count), 32'd1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule